// File: doc/BRIEF.md
# Quad-Lane Execute-in-Place Read Engine

This block is the read side of a serial memory slave that answers two quad-lane read commands. In the first, the opcode and a 24-bit address arrive one bit per clock on lane 0, and the data returns four bits per clock. In the second, the opcode still arrives on lane 0 but the address arrives four bits per clock. In both commands a two-clock mode byte follows the address, after which the block drives data nibbles on all four lanes until chip select rises. The block reads bytes from a synchronous memory port, one cycle of latency, using an address counter that advances by one per byte and wraps at the top of the array.

The mode byte controls an execute-in-place latch. A mode byte of EFh sets the latch and any other value clears it. While the latch is set, the next chip-select-low access has no opcode. Its first clocks carry the address, in the lane format of the command that set the latch. The serial clock is sampled by the block's own faster clock, so both idle polarities of the serial clock (low and high) work. Outputs update on serial-clock falling edges and inputs are taken on rising edges.

The controller uses six states. IDLE waits for chip select and goes to ADDR if the latch is set, or to OPCODE if it is not. OPCODE decodes after eight rising edges and goes to ADDR for a known read opcode or to IGNORE for any other. ADDR goes to MODE after the last address clock. MODE goes to DATA after its second clock. DATA and IGNORE hold. Chip select high returns every state to IDLE.

Top module: `qspi_xip_rd`

## Requirements
- R1: After reset no lane is driven, no memory read is requested, and the execute-in-place latch is clear, so the first access takes an opcode.
- R2: Opcode 6Bh, shifted most-significant bit first on lane 0 over 8 rising edges, selects a read whose 24 address bits follow most-significant bit first on lane 0, one bit per rising edge.
- R3: Opcode EBh selects a read whose 24 address bits follow in 6 rising edges, 4 bits per edge, high nibble first, with bit 3 of each nibble on lane 3.
- R4: After the address, the mode byte takes 2 rising edges with the high nibble first. Each data byte is then sent as two nibbles, high first, with bit 7 on lane 3 and bit 4 on lane 0. The first nibble appears after the falling edge that follows the second mode rising edge. The output changes only after a serial-clock falling edge.
- R5: The output enables are all four high from the first data falling edge until chip select rises, and all four low at every other time, including every opcode, address and mode clock. They fall within 2 system clocks of chip select rising.
- R6: A mode byte of EFh sets the execute-in-place latch, and any other value (FFh included) clears it. The latch and the command kind are captured on the second mode rising edge.
- R7: While the latch is set, the next access begins with the address in the lane format (one lane or four lanes) of the command that set the latch, with no opcode.
- R8: Any opcode other than 6Bh or EBh leaves all lanes undriven until chip select rises.
- R9: Only the low 17 address bits select the byte. The address advances by one per byte and wraps from 1FFFFh to 00000h.
- R10: Operation is the same whether the serial clock idles low or high when chip select falls.
- R11: Chip select rising in any state ends the access. A mode byte that is not completed leaves the latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock, already synchronous to clk |
| cs_n | input | 1 | Active-low chip select, synchronous to clk |
| io_in | input | 4 | Lane input values |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Per-lane output enable |
| mem_addr | output | 17 | Byte address to the memory |
| mem_rd_en | output | 1 | Read strobe; data valid on the next cycle |
| mem_rdata | input | 8 | Byte returned by the memory |

## Verification
The assertions assume that sck and cs_n are already synchronous to clk. They also assume that each serial-clock half period lasts several system clocks, so that every edge is seen and a prefetched byte arrives before the next falling edge. Chip select is assumed to change only while the serial clock is steady, at least a few system clocks after its fall.

The stimulus holds each serial half period for five system clocks. It changes inputs only on the falling edge of clk, and waits several clocks after chip select falls before the first serial edge. The sequences cover both read formats, setting, keeping and clearing the latch, an aborted latched access, an unknown opcode, address wrap, ignored upper address bits and a high-idle serial clock.

// File: rtl/qrd_pkg.sv
package qrd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_MODE,
        ST_DATA,
        ST_IGNORE
    } qrd_state_e;

    localparam logic [7:0] OPC_QUAD_OUT  = 8'h6B;
    localparam logic [7:0] OPC_QUAD_IO   = 8'hEB;
    localparam logic [7:0] MODE_XIP_HOLD = 8'hEF;

endpackage

// File: rtl/qrd_ctrl.sv
module qrd_ctrl
    import qrd_pkg::*;
#(
    parameter int ADDR_W        = 17,
    parameter int SER_ADDR_BITS = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic [3:0]        io_in,
    output logic              in_data,
    output logic              sck_fall,
    output logic              ld,
    output logic [ADDR_W-1:0] ld_addr
);

    localparam int QUAD_CLKS = SER_ADDR_BITS / 4;
    localparam int CNT_W     = $clog2(SER_ADDR_BITS + 1);

    qrd_state_e state, state_nx;

    logic                     sck_q;
    logic                     sck_rise;
    logic [CNT_W-1:0]         cnt;
    logic                     quad;
    logic                     xip_on;
    logic                     xip_quad;
    logic [SER_ADDR_BITS-1:0] sh;
    logic [SER_ADDR_BITS-1:0] sh_nx;
    logic [3:0]               mode_hi;
    logic [7:0]               opc_nx;
    logic                     addr_last;

    assign sck_rise = sck & ~sck_q;
    assign sck_fall = ~sck & sck_q;
    assign in_data  = (state == ST_DATA);

    assign opc_nx    = {sh[6:0], io_in[0]};
    assign sh_nx     = quad ? {sh[SER_ADDR_BITS-5:0], io_in}
                            : {sh[SER_ADDR_BITS-2:0], io_in[0]};
    assign addr_last = quad ? (cnt == CNT_W'(QUAD_CLKS - 1))
                            : (cnt == CNT_W'(SER_ADDR_BITS - 1));

    // next-state logic
    always_comb begin
        state_nx = state;
        if (cs_n) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   state_nx = xip_on ? ST_ADDR : ST_OPCODE;
                ST_OPCODE: if (sck_rise && cnt == CNT_W'(7)) begin
                               if (opc_nx == OPC_QUAD_OUT || opc_nx == OPC_QUAD_IO)
                                   state_nx = ST_ADDR;
                               else
                                   state_nx = ST_IGNORE;
                           end
                ST_ADDR:   if (sck_rise && addr_last) state_nx = ST_MODE;
                ST_MODE:   if (sck_rise && cnt == CNT_W'(1)) state_nx = ST_DATA;
                ST_DATA:   state_nx = ST_DATA;
                ST_IGNORE: state_nx = ST_IGNORE;
                default:   state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // phase outputs and capture registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q    <= 1'b0;
            cnt      <= '0;
            quad     <= 1'b0;
            xip_on   <= 1'b0;
            xip_quad <= 1'b0;
            sh       <= '0;
            mode_hi  <= '0;
            ld       <= 1'b0;
            ld_addr  <= '0;
        end else begin
            sck_q <= sck;
            ld    <= 1'b0;
            if (state != state_nx)
                cnt <= '0;
            else if (sck_rise && (state == ST_OPCODE || state == ST_ADDR || state == ST_MODE))
                cnt <= cnt + CNT_W'(1);

            if (!cs_n) begin
                unique case (state)
                    ST_IDLE:   quad <= xip_on & xip_quad;
                    ST_OPCODE: if (sck_rise) begin
                                   sh <= {sh[SER_ADDR_BITS-2:0], io_in[0]};
                                   if (cnt == CNT_W'(7)) quad <= (opc_nx == OPC_QUAD_IO);
                               end
                    ST_ADDR:   if (sck_rise) begin
                                   sh <= sh_nx;
                                   if (addr_last) begin
                                       ld      <= 1'b1;
                                       ld_addr <= sh_nx[ADDR_W-1:0];
                                   end
                               end
                    ST_MODE:   if (sck_rise) begin
                                   if (cnt == CNT_W'(0)) begin
                                       mode_hi <= io_in;
                                   end else begin
                                       xip_on   <= ({mode_hi, io_in} == MODE_XIP_HOLD);
                                       xip_quad <= quad;
                                   end
                               end
                    ST_DATA, ST_IGNORE: ;
                    default: ;
                endcase
            end
        end
    end

    assert_cs_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (state == ST_IDLE));

    assert_ld_into_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ld |-> (state == ST_MODE));

    assert_latch_in_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (xip_on != $past(xip_on)) |-> ($past(state) == ST_MODE));

endmodule

// File: rtl/qrd_out.sv
module qrd_out #(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_data,
    input  logic              sck_fall,
    input  logic              ld,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [7:0]        mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe
);

    logic       rd_q;
    logic [7:0] pf_byte;
    logic [3:0] lo_nib;
    logic       nib_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_addr  <= '0;
            mem_rd_en <= 1'b0;
            rd_q      <= 1'b0;
            pf_byte   <= '0;
            lo_nib    <= '0;
            nib_hi    <= 1'b1;
            io_out    <= '0;
            io_oe     <= '0;
        end else begin
            mem_rd_en <= 1'b0;
            rd_q      <= mem_rd_en;
            if (rd_q) pf_byte <= mem_rdata;

            if (ld) begin
                mem_addr  <= ld_addr;
                mem_rd_en <= 1'b1;
            end

            if (!in_data) begin
                io_oe  <= '0;
                nib_hi <= 1'b1;
            end else if (sck_fall) begin
                if (nib_hi) begin
                    io_out    <= pf_byte[7:4];
                    lo_nib    <= pf_byte[3:0];
                    io_oe     <= 4'hF;
                    mem_addr  <= mem_addr + ADDR_W'(1);
                    mem_rd_en <= 1'b1;
                    nib_hi    <= 1'b0;
                end else begin
                    io_out <= lo_nib;
                    nib_hi <= 1'b1;
                end
            end
        end
    end

    assert_oe_only_in_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (io_oe != 4'h0) |-> (in_data || $past(in_data)));

    assert_out_moves_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && $past(in_data) && !$past(sck_fall)) |-> $stable(io_out));

endmodule

// File: rtl/qspi_xip_rd.sv
module qspi_xip_rd #(
    parameter int ADDR_W        = 17,
    parameter int SER_ADDR_BITS = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic [3:0]        io_in,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    input  logic [7:0]        mem_rdata
);

    logic              in_data;
    logic              sck_fall;
    logic              ld;
    logic [ADDR_W-1:0] ld_addr;

    qrd_ctrl #(
        .ADDR_W        (ADDR_W),
        .SER_ADDR_BITS (SER_ADDR_BITS)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .cs_n     (cs_n),
        .io_in    (io_in),
        .in_data  (in_data),
        .sck_fall (sck_fall),
        .ld       (ld),
        .ld_addr  (ld_addr)
    );

    qrd_out #(
        .ADDR_W (ADDR_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (in_data),
        .sck_fall  (sck_fall),
        .ld        (ld),
        .ld_addr   (ld_addr),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_rd_en (mem_rd_en),
        .io_out    (io_out),
        .io_oe     (io_oe)
    );

endmodule

// File: tb/sim_qspi_xip_rd.sv
module sim_qspi_xip_rd;

    localparam int AW = 17;
    localparam int H  = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sck = 1'b0;
    logic          cs_n = 1'b1;
    logic [3:0]    io_in = 4'h0;
    logic [3:0]    io_out;
    logic [3:0]    io_oe;
    logic [AW-1:0] mem_addr;
    logic          mem_rd_en;
    logic [7:0]    mem_rdata = 8'h00;

    int   nvec = 0;
    int   nfail = 0;
    logic [7:0] exp_q[$];
    logic  cap_en = 1'b0;
    logic  quiet_en = 1'b0;
    string quiet_tag = "R5";
    string data_tag = "R2";

    always #2 clk = ~clk;

    qspi_xip_rd u0 (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .io_in(io_in),
        .io_out(io_out), .io_oe(io_oe), .mem_addr(mem_addr),
        .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] pat(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ {a[16], 7'h35};
    endfunction

    // memory model: one cycle latency
    always @(posedge clk) if (mem_rd_en) mem_rdata <= pat(mem_addr);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: samples at each serial rising edge
    logic       mon_hi = 1'b1;
    logic [3:0] mon_nib = 4'h0;
    always @(posedge sck) begin
        if (!cap_en) begin
            mon_hi = 1'b1;
            if (quiet_en) check(io_oe == 4'h0, quiet_tag, io_oe, 0);
        end else if (mon_hi) begin
            check(io_oe == 4'hF, "R5", io_oe, 4'hF);
            mon_nib = io_out;
            mon_hi  = 1'b0;
        end else begin
            if (exp_q.size() == 0) begin
                check(1'b0, data_tag, {mon_nib, io_out}, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check({mon_nib, io_out} == e, data_tag, {mon_nib, io_out}, e);
            end
            mon_hi = 1'b1;
        end
    end

    task automatic bitclk(input logic [3:0] v);
        @(negedge clk);
        sck = 1'b0;
        io_in = v;
        repeat (H) @(negedge clk);
        sck = 1'b1;
        repeat (H - 1) @(negedge clk);
    endtask

    task automatic begin_cs(input bit m3);
        @(negedge clk);
        sck = m3;
        repeat (2) @(negedge clk);
        cs_n = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic end_cs(input bit m3);
        if (!m3) begin
            @(negedge clk);
            sck = 1'b0;
            repeat (H) @(negedge clk);
        end
        @(negedge clk);
        cs_n = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check(io_oe == 4'h0, "R5", io_oe, 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic xfer(input bit send_op, input logic [7:0] op, input bit qa,
                        input logic [23:0] addr, input logic [7:0] mode,
                        input int nbytes, input bit m3, input string tag);
        data_tag = tag;
        quiet_tag = "R5";
        quiet_en = 1'b1;
        begin_cs(m3);
        if (send_op) for (int i = 0; i < 8; i++) bitclk({3'b000, op[7-i]});
        if (qa) for (int i = 0; i < 6; i++) bitclk(addr[23-4*i -: 4]);
        else    for (int i = 0; i < 24; i++) bitclk({3'b000, addr[23-i]});
        bitclk(mode[7:4]);
        bitclk(mode[3:0]);
        for (int b = 0; b < nbytes; b++) exp_q.push_back(pat(addr[AW-1:0] + AW'(b)));
        cap_en = 1'b1;
        for (int i = 0; i < 2 * nbytes; i++) bitclk(4'h0);
        cap_en = 1'b0;
        quiet_en = 1'b0;
        end_cs(m3);
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1: quiet after reset
        check(io_oe == 4'h0, "R1", io_oe, 0);
        check(mem_rd_en == 1'b0, "R1", mem_rd_en, 0);

        // R1 R2: first access takes an opcode; single-lane address
        xfer(1, 8'h6B, 0, 24'h000123, 8'hFF, 4, 0, "R2");
        // R3: four-lane address
        xfer(1, 8'hEB, 1, 24'h00A5C0, 8'hFF, 5, 0, "R3");
        // R4: another pattern, mode byte nibble order, data nibble order
        xfer(1, 8'hEB, 1, 24'h01F00F, 8'h00, 3, 0, "R4");

        // R6 R7: set latch with quad read, next access has no opcode
        xfer(1, 8'hEB, 1, 24'h000400, 8'hEF, 2, 0, "R6");
        xfer(0, 8'h00, 1, 24'h000777, 8'hEF, 3, 0, "R7");
        // R11: aborted latched access keeps the latch
        quiet_tag = "R11";
        quiet_en = 1'b1;
        begin_cs(0);
        for (int i = 0; i < 3; i++) bitclk(4'hA);
        quiet_en = 1'b0;
        end_cs(0);
        xfer(0, 8'h00, 1, 24'h001234, 8'hFF, 2, 0, "R11");
        // R6: FFh cleared the latch, opcode taken again
        xfer(1, 8'h6B, 0, 24'h000050, 8'hFF, 2, 0, "R6");

        // R7: latch set by single-lane-address read keeps that format
        xfer(1, 8'h6B, 0, 24'h00B00B, 8'hEF, 2, 0, "R7");
        xfer(0, 8'h00, 0, 24'h00C0DE, 8'h12, 2, 0, "R7");
        xfer(1, 8'hEB, 1, 24'h000001, 8'hFF, 2, 0, "R6");

        // R8: unknown opcode never drives
        quiet_tag = "R8";
        quiet_en = 1'b1;
        begin_cs(0);
        for (int i = 0; i < 8; i++) bitclk({3'b000, 8'h03 >> (7 - i)} & 4'h1);
        for (int i = 0; i < 40; i++) bitclk(4'h0);
        quiet_en = 1'b0;
        end_cs(0);
        xfer(1, 8'h6B, 0, 24'h000200, 8'hFF, 2, 0, "R8");

        // R9: wrap past top, and upper address bits ignored
        xfer(1, 8'hEB, 1, 24'h01FFFE, 8'hFF, 4, 0, "R9");
        xfer(1, 8'h6B, 0, 24'hFE0010, 8'hFF, 2, 0, "R9");

        // R10: serial clock idling high
        xfer(1, 8'hEB, 1, 24'h003330, 8'hFF, 3, 1, "R10");
        xfer(1, 8'h6B, 0, 24'h010101, 8'hFF, 3, 1, "R10");

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule